// File: doc/BRIEF.md
# Timed Unlock for Sleep Brown-out Disable

This block guards the control bit that lets the brown-out detector be switched off while the chip sleeps. Software must use a two-write unlock sequence to set the bit. The first write sets both low bits to one, which opens a short window. A second write inside that window, with pattern `10` on the low bits, sets the disable bit.

Once set, the disable bit passes through a short pending phase and then a short active phase. After that it clears itself. A sleep request that arrives during the active phase latches the detector-off output. That output stays set until the wake input is raised.

Every port is a plain control or status pin. There is no data stream, so there is no valid/ready handshake and no back-pressure. The block samples a register write on every clock edge where `wr_en` is high, and it never stalls the core.

Top module: `bod_sleep_guard`

## Requirements
- R1: `rd_data` shows the disable bit at bit 1 and the enable bit at bit 0. Bits 7..2 always read zero, whatever was written.
- R2: After reset, `rd_data` is zero and `det_off` is low.
- R3: A write whose low two bits are `11` opens the window. The enable bit then reads one for exactly WIN_CYC (4) cycles and clears itself if no other write arrives. A new `11` write restarts the window.
- R4: A write with low bits `10`, made on any edge while the enable bit reads one, sets the disable bit and clears the enable bit at that same edge. This includes the fourth cycle after the opening write.
- R5: Inside the window, any write whose low bits are neither `11` nor `10` aborts the sequence: the enable bit clears and the disable bit is unchanged. A `10` write while the window is closed has no effect.
- R6: Once set, the disable bit reads one for DLY_CYC+HOLD_CYC (3+3) cycles and then clears itself. Writes never clear it early.
- R7: `sleep_off_now` is high only during the last HOLD_CYC cycles of that period. It is low during the first DLY_CYC cycles.
- R8: A `sleep_req` sampled while `sleep_off_now` is high sets `det_off` at that edge. At any other time, `sleep_req` has no effect on `det_off`.
- R9: `det_off` stays high until `wake` is sampled high, and `wake` then clears it. `wake` wins over a `sleep_req` on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe from the core |
| wr_data | input | 8 | Write data; only bits 1..0 matter |
| rd_data | output | 8 | Register read value |
| sleep_req | input | 1 | Sleep instruction executed this cycle |
| wake | input | 1 | Wake-up event; ends a detector-off period |
| sleep_off_now | output | 1 | A sleep arriving now would switch the detector off |
| det_off | output | 1 | Detector switched off for the current sleep |

## Verification
The assertions assume that every input is a clean synchronous level that is sampled once per edge. They also assume that `sleep_req` and `wake` may arrive on any cycle, including during a write.

The stimulus mixes random writes, sleeps and wakes, drawn from a fixed seed and changed only between clock edges. Writes are biased toward the two unlock codes, so that windows, aborts and active phases happen often. Directed sequences cover the last valid window edge, a late second write, an abort, and a sleep during the pending phase.

// File: rtl/bodg_pkg.sv
package bodg_pkg;
  localparam int unsigned WIN_DEF  = 4;
  localparam int unsigned DLY_DEF  = 3;
  localparam int unsigned HOLD_DEF = 3;
  localparam logic [1:0] CODE_OPEN = 2'b11;
  localparam logic [1:0] CODE_SET  = 2'b10;
endpackage

// File: rtl/bodg_window.sv
module bodg_window #(
  parameter int unsigned WIN_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cancel_i,
  output logic open_o
);
  localparam int unsigned CW = $clog2(WIN_CYC + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        left_q <= '0;
    else if (start_i)  left_q <= CW'(WIN_CYC);
    else if (cancel_i) left_q <= '0;
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign open_o = (left_q != '0);
endmodule

// File: rtl/bodg_arm_timer.sv
module bodg_arm_timer #(
  parameter int unsigned DLY_CYC  = 3,
  parameter int unsigned HOLD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic set_o,
  output logic active_o
);
  localparam int unsigned TOTAL = DLY_CYC + HOLD_CYC;
  localparam int unsigned CW    = $clog2(TOTAL + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load_i)       cnt_q <= CW'(TOTAL);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign set_o    = (cnt_q != '0);
  assign active_o = set_o && (cnt_q <= CW'(HOLD_CYC));
endmodule

// File: rtl/bodg_off_hold.sv
module bodg_off_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic active_i,
  input  logic wake_i,
  output logic off_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                     off_o <= 1'b0;
    else if (wake_i)                off_o <= 1'b0;
    else if (sleep_i && active_i)   off_o <= 1'b1;
  end
endmodule

// File: rtl/bod_sleep_guard.sv
module bod_sleep_guard
  import bodg_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned WIN_CYC  = WIN_DEF,
  parameter int unsigned DLY_CYC  = DLY_DEF,
  parameter int unsigned HOLD_CYC = HOLD_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sleep_req,
  input  logic              wake,
  output logic              sleep_off_now,
  output logic              det_off
);
  localparam int unsigned PAD_W = DATA_W - 2;

  logic [1:0] code;
  logic       wr_open, wr_set, win_open, arm_load, dis_bit, unused_hi;

  assign code      = wr_data[1:0];
  assign unused_hi = ^wr_data[DATA_W-1:2];
  assign wr_open   = wr_en && (code == CODE_OPEN);
  assign wr_set    = wr_en && (code == CODE_SET);
  assign arm_load  = wr_set && win_open;

  bodg_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n),
    .start_i(wr_open),
    .cancel_i(wr_en && !wr_open),
    .open_o(win_open)
  );

  bodg_arm_timer #(.DLY_CYC(DLY_CYC), .HOLD_CYC(HOLD_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .load_i(arm_load),
    .set_o(dis_bit),
    .active_o(sleep_off_now)
  );

  bodg_off_hold u_off (
    .clk(clk), .rst_n(rst_n),
    .sleep_i(sleep_req),
    .active_i(sleep_off_now),
    .wake_i(wake),
    .off_o(det_off)
  );

  assign rd_data = {{PAD_W{1'b0}}, dis_bit, win_open};
endmodule

// File: rtl/bodg_checker.sv
module bodg_checker #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned WIN_CYC  = 4,
  parameter int unsigned HOLD_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_code,
  input logic [DATA_W-1:0] rd_data,
  input logic              sleep_req,
  input logic              wake,
  input logic              sleep_off_now,
  input logic              det_off
);
  int unsigned en_run, act_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_run  <= 0;
      act_run <= 0;
    end else begin
      en_run  <= (wr_en && wr_code == 2'b11) ? 1 : (rd_data[0] ? en_run + 1 : 0);
      act_run <= sleep_off_now ? act_run + 1 : 0;
    end
  end

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:2] == '0);

  p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] |-> en_run <= WIN_CYC);

  p_set_needs_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[1]) |-> $past(wr_en && wr_code == 2'b10 && rd_data[0]));

  p_active_in_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_off_now |-> rd_data[1]);

  p_active_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_off_now |-> act_run < HOLD_CYC);

  p_off_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_off) |-> $past(sleep_req && sleep_off_now && !wake));

  p_wake_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !det_off);

  p_off_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (det_off && !wake) |=> det_off);
endmodule

bind bod_sleep_guard bodg_checker #(
  .DATA_W(DATA_W), .WIN_CYC(WIN_CYC), .HOLD_CYC(HOLD_CYC)
) i_bodg_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_data[1:0]),
  .rd_data(rd_data), .sleep_req(sleep_req), .wake(wake),
  .sleep_off_now(sleep_off_now), .det_off(det_off)
);

// File: tb/test_bod_sleep_guard.sv
`timescale 1ns/1ps
module test_bod_sleep_guard;
  localparam int WIN = 4, DLY = 3, HOLD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, sleep_req = 1'b0, wake = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic sleep_off_now, det_off;

  int checks = 0, errors = 0;
  int m_win = 0, m_cnt = 0;
  bit m_off = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bod_sleep_guard i_bod_sleep_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sleep_req(sleep_req), .wake(wake),
    .sleep_off_now(sleep_off_now), .det_off(det_off)
  );

  function automatic bit exp_active(int cnt);
    return (cnt > 0) && (cnt <= HOLD);
  endfunction

  function automatic logic [7:0] exp_rd(int win, int cnt);
    return {6'b0, cnt > 0, win > 0};
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // model compare, then drive one cycle of inputs and advance the model
  task automatic step(input bit we, input logic [7:0] d, input bit slp, input bit wk);
    bit w_open, w_set;
    @(negedge clk);
    check("R1 reserved", int'(rd_data[7:2]), 0);
    check("R3 enable bit", int'(rd_data[0]), int'(exp_rd(m_win, m_cnt)) & 1);
    check("R6 disable bit", int'(rd_data[1]), int'(m_cnt > 0));
    check("R7 sleep_off_now", int'(sleep_off_now), int'(exp_active(m_cnt)));
    check("R9 det_off", int'(det_off), int'(m_off));
    wr_en = we; wr_data = d; sleep_req = slp; wake = wk;
    w_open = we && d[1:0] == 2'b11;
    w_set  = we && d[1:0] == 2'b10;
    if (wk) m_off = 1'b0;
    else if (slp && exp_active(m_cnt)) m_off = 1'b1;
    if (w_set && m_win > 0) m_cnt = DLY + HOLD;
    else if (m_cnt > 0) m_cnt--;
    if (w_open) m_win = WIN;
    else if (we) m_win = 0;
    else if (m_win > 0) m_win--;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic peek(input string tag, input int got_sel, input int exp);
    int got;
    @(posedge clk); #1;
    case (got_sel)
      0: got = int'(rd_data);
      1: got = int'(sleep_off_now);
      default: got = int'(det_off);
    endcase
    check(tag, got, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R2 reset rd_data", int'(rd_data), 0);
    check("R2 reset det_off", int'(det_off), 0);

    // R3: window length
    step(1'b1, 8'h03, 0, 0); peek("R3 window opens", 0, 8'h01);
    idle(3);                 peek("R3 still open cycle 4", 0, 8'h01);
    idle(1);                 peek("R3 window expired", 0, 8'h00);

    // R4 last valid edge, R1 upper bits ignored, R6/R7 timeline, R8/R9
    step(1'b1, 8'hFF, 0, 0); idle(3);
    step(1'b1, 8'hFE, 0, 0); peek("R4 set on 4th edge", 0, 8'h02);
    idle(2);                 peek("R7 pending phase", 1, 0);
    idle(1);                 peek("R7 active phase", 1, 1);
    step(1'b0, 8'h00, 1, 0); peek("R8 sleep latched", 2, 1);
    step(1'b1, 8'h00, 0, 0); idle(1);
    peek("R6 self clear", 0, 8'h00);
    idle(2);                 peek("R9 held", 2, 1);
    step(1'b0, 8'h00, 1, 1); peek("R9 wake wins", 2, 0);

    // R5: late second write
    step(1'b1, 8'h03, 0, 0); idle(4);
    step(1'b1, 8'h02, 0, 0); peek("R5 late write ignored", 0, 8'h00);
    // R5: abort then retry in old window
    step(1'b1, 8'h03, 0, 0);
    step(1'b1, 8'h01, 0, 0); peek("R5 abort clears enable", 0, 8'h00);
    step(1'b1, 8'h02, 0, 0); peek("R5 no set after abort", 0, 8'h00);

    // R8: sleep during pending phase ignored
    step(1'b1, 8'h03, 0, 0);
    step(1'b1, 8'h02, 0, 0);
    step(1'b0, 8'h00, 1, 0); peek("R8 pending sleep ignored", 2, 0);
    idle(8);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(99));
      bit we = (r < 40);
      logic [7:0] d = 8'($urandom());
      if ($urandom_range(2) != 0) d[1:0] = ($urandom_range(1) != 0) ? 2'b11 : 2'b10;
      step(we, d, $urandom_range(9) == 0, $urandom_range(19) == 0);
    end
    idle(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule